// File: doc/BRIEF.md
# DMA Channel Start and Interrupt Control Registers

This block holds the register state of a seven-channel DMA controller. It does not move any data. Each channel has three registers: a memory address, a block count and a channel control word. Two shared registers sit beside them. The channel-enable register gives each channel an enable bit. The interrupt register combines software-writable enables with per-channel completion flags.

When software writes a channel's control word with the start bit set, and that channel is enabled, the block sends a one-cycle start pulse to the channel's transfer engine. The engine answers later with a one-cycle done pulse. The done pulse clears the start bit. If that channel's flag enable is set, the done pulse also raises the channel's completion flag.

From the flags, the global enable and the bus-error bit, the block forms an interrupt condition. It sends a single pulse to the system interrupt controller each time that condition goes from false to true.

Top module: `dma_ctl_regs`

## Requirements
- R1: After reset every register reads zero and `ch_start`, `restart_warn` and `sys_irq` are low.
- R2: Register map on the 8-bit offset:
  - Channel n address is at 0x80+0x10·n.
  - Channel n block count is at 0x84+0x10·n.
  - Channel n control word is at 0x88+0x10·n.
  - The channel-enable register is at 0xF0.
  - Each of these holds the full 32-bit write value and reads it back on `rd_data` combinationally.
- R3: A write to channel n's control word with bit 24 set, while bit 4·n+3 of the channel-enable register is 1 before the write, drives `ch_start[n]` high for exactly the one cycle after the write edge. No other bit of `ch_start` goes high.
- R4: Channel 5 never produces a start pulse, whatever is written. Its registers still store and read back.
- R5: A control-word write with bit 24 set, to a channel whose stored bit 24 is already 1, drives `restart_warn` high for the cycle after the write.
- R6: A `ch_done[n]` pulse clears bit 24 of channel n's control word. If a control write to the same channel happens in the same cycle, the written value is kept.
- R7: A write to the interrupt register at 0xF4 stores only the bits in mask 0x00FF803F. The stored fields are:
  - bits 5:0 are plain storage;
  - bit 15 is the bus-error bit;
  - bits 22:16 are the per-channel flag enables;
  - bit 23 is the global enable.
  Bits 14:6 always read zero.
- R8: The completion flags sit at bits 30:24 of the interrupt register.
  - Writing a 1 to a flag bit clears that flag; writing a 0 keeps it.
  - `ch_done[n]` sets flag n only when enable bit 16+n is 1.
  - If a set and a clear reach the same flag in the same cycle, the set wins.
- R9: The interrupt condition is (bit 23 AND any flag) OR bit 15. When the condition is true and the sent bit (bit 31) is clear, `sys_irq` is high for one cycle and the sent bit then reads 1.
- R10: While the condition is false the sent bit reads 0 from the next cycle on, so a later return of the condition pulses `sys_irq` again.
- R11: Writes to unmapped offsets change nothing. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 32 | Write value |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 32 | Combinational read value |
| ch_done | input | 7 | Per-channel transfer-complete pulses |
| ch_start | output | 7 | Per-channel start pulses |
| restart_warn | output | 1 | Start requested while a channel was already busy |
| sys_irq | output | 1 | Interrupt pulse to the system controller |

## Verification
The bench targets the following corner cases, and what a wrong design would do in each:

- **Channel-enable bit:** the start pulse depends on a bit picked by channel index. A wrong bit position starts the wrong channel or starts none.
- **Channel 5:** a design missing its start exclusion would pulse channel 5.
- **Same-cycle collisions:** a done pulse together with a control rewrite, and a done pulse together with a one-to-clear write of its flag, expose the wrong priority. Either a busy bit or a completion flag would be lost.
- **Interrupt re-arm:** repeated interrupt-register writes and flag clears check that the interrupt fires once per rising edge of the condition. A level-driven output would fire every cycle. A sent bit that never clears would silence every interrupt after the first.

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs #(
  parameter int NCH = 7,
  parameter logic [NCH-1:0] START_MASK = 7'b1011111
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  input  logic [6:0]  ch_done,
  output logic [6:0]  ch_start,
  output logic        restart_warn,
  output logic        sys_irq
);
  localparam logic [31:0] ICR_WMASK = 32'h00FF803F;
  localparam int BUSY_BIT = 24;

  logic [31:0] madr [NCH];
  logic [31:0] bcnt [NCH];
  logic [31:0] chcr [NCH];
  logic [31:0] pcr;
  logic [23:0] icr_ctl;
  logic [NCH-1:0] flags;
  logic sent;

  wire [2:0] wch    = wr_addr[6:4];
  wire       wr_ch  = wr_en && wr_addr[7] && (wch != 3'd7);
  wire       wr_sys = wr_en && (wr_addr[7:4] == 4'hF);
  wire       wr_icr = wr_sys && (wr_addr[3:0] == 4'h4);
  wire [NCH-1:0] clr_mask = wr_icr ? wr_data[24 +: NCH] : '0;

  wire irq_cond = (icr_ctl[23] && |flags) || icr_ctl[15];
  assign sys_irq = irq_cond && !sent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NCH; n++) begin
        madr[n] <= '0;
        bcnt[n] <= '0;
        chcr[n] <= '0;
      end
      pcr <= '0;
      icr_ctl <= '0;
      flags <= '0;
      sent <= 1'b0;
      ch_start <= '0;
      restart_warn <= 1'b0;
    end else begin
      ch_start <= '0;
      restart_warn <= 1'b0;
      for (int n = 0; n < NCH; n++)
        if (ch_done[n]) chcr[n][BUSY_BIT] <= 1'b0;
      if (wr_ch) begin
        case (wr_addr[3:0])
          4'h0: madr[wch] <= wr_data;
          4'h4: bcnt[wch] <= wr_data;
          4'h8: begin
            chcr[wch] <= wr_data;
            restart_warn <= wr_data[BUSY_BIT] && chcr[wch][BUSY_BIT];
            ch_start[wch] <= wr_data[BUSY_BIT] && pcr[{wch, 2'b11}] && START_MASK[wch];
          end
          default: ;
        endcase
      end
      if (wr_sys && wr_addr[3:0] == 4'h0) pcr <= wr_data;
      if (wr_icr) icr_ctl <= wr_data[23:0] & ICR_WMASK[23:0];
      flags <= (flags & ~clr_mask) | (ch_done & icr_ctl[16 +: NCH]);
      sent <= irq_cond;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr[7] && rd_addr[6:4] != 3'd7) begin
      case (rd_addr[3:0])
        4'h0: rd_data = madr[rd_addr[6:4]];
        4'h4: rd_data = bcnt[rd_addr[6:4]];
        4'h8: rd_data = chcr[rd_addr[6:4]];
        default: rd_data = '0;
      endcase
    end else if (rd_addr == 8'hF0) begin
      rd_data = pcr;
    end else if (rd_addr == 8'hF4) begin
      rd_data = {sent, flags, icr_ctl};
    end
  end

  assert_one_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ch_start));
  assert_start_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |ch_start |-> $past(wr_en));
  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_irq |=> !sys_irq);
  assert_irq_marks_sent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sys_irq |=> rd_data[31] || rd_addr != 8'hF4 || !irq_cond || sent);
  assert_flag_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    |(flags & ~$past(flags)) |-> $past(|ch_done));
endmodule

// File: tb/dma_ctl_regs_tb_top.sv
module dma_ctl_regs_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, wr_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [6:0]  ch_done, ch_start;
  logic        restart_warn, sys_irq;

  dma_ctl_regs dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ch_done(ch_done),
    .ch_start(ch_start), .restart_warn(restart_warn), .sys_irq(sys_irq));

  int tests = 0, fails = 0;
  logic [31:0] m_madr [7], m_bcnt [7], m_chcr [7];
  logic [31:0] m_pcr;
  logic [23:0] m_icr;
  logic [6:0]  m_flags;
  logic        m_sent;
  logic [6:0]  e_start;
  logic        e_warn;

  function automatic logic cond_of(logic [23:0] icr, logic [6:0] fl);
    return (icr[23] && |fl) || icr[15];
  endfunction

  function automatic logic [31:0] read_exp(logic [7:0] a);
    if (a[7] && a[6:4] != 3'd7) begin
      if (a[3:0] == 4'h0) return m_madr[a[6:4]];
      if (a[3:0] == 4'h4) return m_bcnt[a[6:4]];
      if (a[3:0] == 4'h8) return m_chcr[a[6:4]];
      return 32'h0;
    end
    if (a == 8'hF0) return m_pcr;
    if (a == 8'hF4) return {m_sent, m_flags, m_icr};
    return 32'h0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic we, logic [7:0] wa, logic [31:0] wd, logic [6:0] dn, logic [7:0] ra);
    logic [6:0] clr;
    logic [2:0] c;
    wr_en = we; wr_addr = wa; wr_data = wd; ch_done = dn; rd_addr = ra;
    e_start = '0; e_warn = 1'b0;
    clr = '0;
    c = wa[6:4];
    m_sent = cond_of(m_icr, m_flags);
    if (we && wa[7] && c != 3'd7 && wa[3:0] == 4'h8) begin
      e_warn = wd[24] && m_chcr[c][24];
      e_start[c] = wd[24] && m_pcr[4*c+3] && (c != 3'd5);
    end
    for (int n = 0; n < 7; n++) if (dn[n]) m_chcr[n][24] = 1'b0;
    if (we && wa[7] && c != 3'd7) begin
      if (wa[3:0] == 4'h0) m_madr[c] = wd;
      if (wa[3:0] == 4'h4) m_bcnt[c] = wd;
      if (wa[3:0] == 4'h8) m_chcr[c] = wd;
    end
    if (we && wa == 8'hF4) clr = wd[30:24];
    m_flags = (m_flags & ~clr) | (dn & m_icr[22:16]);
    if (we && wa == 8'hF0) m_pcr = wd;
    if (we && wa == 8'hF4) m_icr = wd[23:0] & 24'hFF803F;
    @(posedge clk); #1;
    check("R3 R4 start", {25'h0, ch_start}, {25'h0, e_start});
    check("R5 warn", {31'h0, restart_warn}, {31'h0, e_warn});
    check("R9 R10 irq", {31'h0, sys_irq}, {31'h0, cond_of(m_icr, m_flags) && !m_sent});
    check("R2 R6 R7 R8 R11 read", rd_data, read_exp(ra));
    @(negedge clk);
  endtask

  function automatic logic [7:0] pick_addr();
    int k = $urandom_range(0, 24);
    if (k < 21) return 8'h80 + 8'((k / 3) * 16 + (k % 3) * 4);
    if (k == 21) return 8'hF0;
    if (k == 22) return 8'hF4;
    if (k == 23) return 8'h8C;
    return 8'h40;
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int n = 0; n < 7; n++) begin m_madr[n] = 0; m_bcnt[n] = 0; m_chcr[n] = 0; end
    m_pcr = 0; m_icr = 0; m_flags = 0; m_sent = 0;
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; ch_done = 0; rd_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 start", {25'h0, ch_start}, 32'h0);
    check("R1 irq", {31'h0, sys_irq}, 32'h0);
    check("R1 warn", {31'h0, restart_warn}, 32'h0);
    for (int a = 0; a < 256; a += 4) begin
      rd_addr = 8'(a); #1;
      check("R1 read", rd_data, 32'h0);
    end
    rst_n = 1;
    // directed corner cases
    step(1, 8'hF0, 32'h0888_8888, 0, 8'hF0);          // R2 all enables
    step(1, 8'h88, 32'h0100_0000, 0, 8'h88);          // R3 start ch0
    step(1, 8'hD8, 32'h0100_0000, 0, 8'hD8);          // R4 ch5 no start
    step(1, 8'h88, 32'h0100_0001, 0, 8'h88);          // R5 restart warn
    step(1, 8'h88, 32'h0100_0002, 7'h01, 8'h88);      // R6 write wins over done
    step(0, 0, 0, 7'h01, 8'h88);                      // R6 done clears busy
    step(1, 8'hF4, 32'hFFFF_FFFF, 0, 8'hF4);          // R7 mask, R9 bus error irq
    step(0, 0, 0, 0, 8'hF4);                          // R9 sent reads 1
    step(1, 8'hF4, 32'h0081_0000, 0, 8'hF4);          // R10 cond false
    step(0, 0, 0, 0, 8'hF4);
    step(0, 0, 0, 7'h01, 8'hF4);                      // R8 flag set, R9 irq again
    step(1, 8'hF4, 32'h0181_0000, 7'h01, 8'hF4);      // R8 set wins over clear
    step(1, 8'hF4, 32'h0181_0000, 0, 8'hF4);          // R8 W1C, R10 rearm
    step(1, 8'h8C, 32'hDEAD_BEEF, 0, 8'h8C);          // R11 unmapped
    step(1, 8'h40, 32'hDEAD_BEEF, 0, 8'hF8);          // R11 unmapped
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] wa = pick_addr();
      logic [31:0] wd = $urandom;
      logic [6:0] dn = 7'($urandom & $urandom & $urandom);
      if (wa == 8'hF4) wd[30:24] = wd[30:24] & 7'($urandom);
      step(($urandom_range(0, 3) != 0), wa, wd, dn, pick_addr());
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule